// File: doc/BRIEF.md
# Link-Aware Transmit Power Controller

This block picks a transmit power setting, in whole dBm, once for each connection event. Each event arrives as a single-cycle strobe that carries the slot type, an 8-bit link-quality value and a signed RSSI reading. Classic-link slots use a link-quality threshold to choose between two fixed levels. Low-energy slots run a fixed-point proportional-integral loop that steers the measured RSSI toward a target. The integral term is collected over a window of a fixed number of low-energy events.

The result is rounded and then saturated to a legal range. It is registered and held until the next event. Upstream logic supplies the measurements. Downstream logic takes `pwr_o` as the amplifier setting for the next transmission.

Top module: `tx_power_ctl`

## Requirements
- R1: When an event arrives with `slot_le_i`=0 (classic slot), the new power is 0 dBm if `lq_i` > 200. Otherwise the new power is +10 dBm.
- R2: When an event arrives with `slot_le_i`=1 (low-energy slot), the error is e = −65 − `rssi_i`. The unrounded power is 0 + e/2 + 0.125·I, where I is the running sum of errors that includes the current event. The arithmetic is signed fixed point with 4 fractional bits.
- R3: The unrounded low-energy power is rounded to the nearest whole dBm before clamping. Exact halves round toward +∞.
- R4: I is the sum of the errors of the low-energy events in the current window. The window closes on every 10th low-energy event, which counts from reset or from the previous close. That event's error is included in its own output, and then I and the window count return to zero.
- R5: `pwr_o` always lies in −20 … +10 dBm. A low-energy result outside that range is saturated to the nearer limit after all terms have been summed.
- R6: `pwr_o` takes its new value at the rising clock edge where `evt_valid_i`=1. It keeps that value on every edge where `evt_valid_i`=0, whatever the other inputs do.
- R7: Classic-slot events leave I and the window count unchanged.
- R8: Asynchronous reset (`rst_ni`=0) sets `pwr_o` to 0 dBm and clears I and the window count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | One-cycle strobe marking a connection event |
| slot_le_i | input | 1 | 1 = low-energy slot, 0 = classic slot |
| lq_i | input | 8 | Link-quality value, unsigned |
| rssi_i | input | 8 | Measured RSSI in dBm, two's complement |
| pwr_o | output | 8 | Transmit power in dBm, two's complement |

## Verification
The bench builds the block with its default parameters: an 8-bit RSSI, 4 fractional bits, a 10-event window, a threshold of 200 and a clamp of −20 … +10 dBm. With these values, a few hundred random events close the integral window many times. The RSSI draws reach both saturation limits, and they also reach the unclamped middle of the range, where the rounding of halves is visible. Directed events cover the threshold values 200 and 201, the extreme RSSI codes, and classic events placed in the middle of a window. Idle cycles with changing inputs are mixed in, so that both the hold behaviour and the isolation of the integrator are exercised.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  // fixed-point helpers shared by the datapath
  localparam int unsigned ERR_GUARD = 2;  // extra bits on the RSSI error
  localparam int unsigned SUM_GUARD = 6;  // extra bits on the Q-format sum
  typedef enum logic {SLOT_CLASSIC = 1'b0, SLOT_LE = 1'b1} slot_e;
endpackage

// File: rtl/tpc_classic_sel.sv
module tpc_classic_sel #(
  parameter int LQ_W   = 8,
  parameter int PWR_W  = 8,
  parameter int LQ_THR = 200,
  parameter int P_HI   = 10,
  parameter int P_LO   = 0
) (
  input  logic [LQ_W-1:0]         lq_i,
  output logic signed [PWR_W-1:0] pwr_o
);
  localparam logic [LQ_W-1:0] THR = LQ_W'(LQ_THR);

  always_comb pwr_o = (lq_i > THR) ? PWR_W'(P_LO) : PWR_W'(P_HI);
endmodule

// File: rtl/tpc_pi_core.sv
module tpc_pi_core #(
  parameter int RSSI_W   = 8,
  parameter int INT_W    = 16,
  parameter int SUM_W    = 24,
  parameter int FRAC     = 4,
  parameter int KP_SHIFT = 1,
  parameter int KI_NUM   = 2,
  parameter int TARGET   = -65,
  parameter int BASE     = 0,
  parameter int WIN      = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic signed [RSSI_W-1:0] rssi_i,
  output logic signed [SUM_W-1:0]  sum_q_o,
  output logic signed [INT_W-1:0]  integ_o,
  output logic [$clog2(WIN)-1:0]   win_cnt_o
);
  localparam int E_W   = RSSI_W + tpc_pkg::ERR_GUARD;
  localparam int CNT_W = $clog2(WIN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN - 1);
  localparam logic signed [SUM_W-1:0] BASE_Q = SUM_W'(BASE * (1 << FRAC));
  localparam logic signed [SUM_W-1:0] KI_S   = SUM_W'(KI_NUM);

  logic signed [E_W-1:0]   err;
  logic signed [INT_W-1:0] integ_q, integ_nx;
  logic [CNT_W-1:0]        cnt_q;

  always_comb begin
    err      = E_W'(TARGET) - E_W'(rssi_i);
    integ_nx = integ_q + INT_W'(err);
    sum_q_o  = BASE_Q
             + ((SUM_W'(err) <<< FRAC) >>> KP_SHIFT)
             + (SUM_W'(integ_nx) * KI_S);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      cnt_q   <= '0;
    end else if (upd_i) begin
      if (cnt_q == CNT_LAST) begin
        integ_q <= '0;
        cnt_q   <= '0;
      end else begin
        integ_q <= integ_nx;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign integ_o   = integ_q;
  assign win_cnt_o = cnt_q;
endmodule

// File: rtl/tpc_round_clamp.sv
module tpc_round_clamp #(
  parameter int SUM_W = 24,
  parameter int FRAC  = 4,
  parameter int PWR_W = 8,
  parameter int P_MIN = -20,
  parameter int P_MAX = 10
) (
  input  logic signed [SUM_W-1:0] sum_q_i,
  output logic signed [PWR_W-1:0] pwr_o
);
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1 << (FRAC - 1));
  localparam logic signed [SUM_W-1:0] MINV = SUM_W'(P_MIN);
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(P_MAX);

  logic signed [SUM_W-1:0] rnd, sat;

  always_comb begin
    rnd = (sum_q_i + HALF) >>> FRAC;
    if (rnd < MINV)      sat = MINV;
    else if (rnd > MAXV) sat = MAXV;
    else                 sat = rnd;
    pwr_o = PWR_W'(sat);
  end
endmodule

// File: rtl/tx_power_ctl.sv
module tx_power_ctl #(
  parameter int LQ_W     = 8,
  parameter int RSSI_W   = 8,
  parameter int PWR_W    = 8,
  parameter int FRAC     = 4,
  parameter int KP_SHIFT = 1,
  parameter int KI_NUM   = 2,
  parameter int TARGET   = -65,
  parameter int BASE     = 0,
  parameter int WIN      = 10,
  parameter int LQ_THR   = 200,
  parameter int P_HI     = 10,
  parameter int P_LO     = 0,
  parameter int P_MIN    = -20,
  parameter int P_MAX    = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     evt_valid_i,
  input  logic                     slot_le_i,
  input  logic [LQ_W-1:0]          lq_i,
  input  logic signed [RSSI_W-1:0] rssi_i,
  output logic signed [PWR_W-1:0]  pwr_o
);
  localparam int E_W   = RSSI_W + tpc_pkg::ERR_GUARD;
  localparam int INT_W = E_W + $clog2(WIN) + 1;
  localparam int SUM_W = INT_W + FRAC + tpc_pkg::SUM_GUARD;
  localparam int CNT_W = $clog2(WIN);

  logic signed [PWR_W-1:0] cls_pwr, le_pwr, pwr_q;
  logic signed [SUM_W-1:0] sum_q;
  logic signed [INT_W-1:0] integ;
  logic [CNT_W-1:0]        win_cnt;
  logic                    le_upd;

  assign le_upd = evt_valid_i && (slot_le_i == tpc_pkg::SLOT_LE);

  tpc_classic_sel #(
    .LQ_W(LQ_W), .PWR_W(PWR_W), .LQ_THR(LQ_THR), .P_HI(P_HI), .P_LO(P_LO)
  ) u_cls (
    .lq_i (lq_i),
    .pwr_o(cls_pwr)
  );

  tpc_pi_core #(
    .RSSI_W(RSSI_W), .INT_W(INT_W), .SUM_W(SUM_W), .FRAC(FRAC),
    .KP_SHIFT(KP_SHIFT), .KI_NUM(KI_NUM), .TARGET(TARGET), .BASE(BASE), .WIN(WIN)
  ) u_pi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (le_upd),
    .rssi_i   (rssi_i),
    .sum_q_o  (sum_q),
    .integ_o  (integ),
    .win_cnt_o(win_cnt)
  );

  tpc_round_clamp #(
    .SUM_W(SUM_W), .FRAC(FRAC), .PWR_W(PWR_W), .P_MIN(P_MIN), .P_MAX(P_MAX)
  ) u_rc (
    .sum_q_i(sum_q),
    .pwr_o  (le_pwr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pwr_q <= '0;
    else if (evt_valid_i) pwr_q <= slot_le_i ? le_pwr : cls_pwr;
  end

  assign pwr_o = pwr_q;
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int LQ_W   = 8,
  parameter int PWR_W  = 8,
  parameter int INT_W  = 16,
  parameter int CNT_W  = 4,
  parameter int WIN    = 10,
  parameter int LQ_THR = 200,
  parameter int P_HI   = 10,
  parameter int P_LO   = 0,
  parameter int P_MIN  = -20,
  parameter int P_MAX  = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    evt_valid_i,
  input logic                    slot_le_i,
  input logic [LQ_W-1:0]         lq_i,
  input logic signed [PWR_W-1:0] pwr_o,
  input logic signed [INT_W-1:0] integ,
  input logic [CNT_W-1:0]        win_cnt
);
  AST_CLASSIC_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !slot_le_i && (int'(lq_i) > LQ_THR) |=> pwr_o == PWR_W'(P_LO)); // R1
  AST_CLASSIC_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !slot_le_i && (int'(lq_i) <= LQ_THR) |=> pwr_o == PWR_W'(P_HI)); // R1
  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(win_cnt) < WIN); // R4
  AST_WIN_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && slot_le_i && (int'(win_cnt) == WIN - 1) |=> (win_cnt == '0) && (integ == '0)); // R4
  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pwr_o) >= P_MIN) && (int'(pwr_o) <= P_MAX)); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> $stable(pwr_o)); // R6
  AST_CLS_NO_INTEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !slot_le_i |=> $stable(integ) && $stable(win_cnt)); // R7

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_STATE: assert (pwr_o == '0 && integ == '0 && win_cnt == '0); // R8
  end
endmodule

bind tx_power_ctl tpc_checker #(
  .LQ_W(LQ_W), .PWR_W(PWR_W), .INT_W(INT_W), .CNT_W(CNT_W), .WIN(WIN),
  .LQ_THR(LQ_THR), .P_HI(P_HI), .P_LO(P_LO), .P_MIN(P_MIN), .P_MAX(P_MAX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_valid_i(evt_valid_i),
  .slot_le_i  (slot_le_i),
  .lq_i       (lq_i),
  .pwr_o      (pwr_o),
  .integ      (integ),
  .win_cnt    (win_cnt)
);

// File: tb/tb_tx_power_ctl.sv
`timescale 1ns/1ps
module tb_tx_power_ctl;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              evt_valid_i = 1'b0;
  logic              slot_le_i = 1'b0;
  logic [7:0]        lq_i = '0;
  logic signed [7:0] rssi_i = '0;
  logic signed [7:0] pwr_o;

  int checks = 0;
  int failures = 0;
  int m_integ = 0;
  int m_cnt = 0;
  int m_pwr = 0;

  tx_power_ctl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i),
    .slot_le_i(slot_le_i), .lq_i(lq_i), .rssi_i(rssi_i), .pwr_o(pwr_o)
  );

  always #2.5 clk_i = ~clk_i;

  function automatic int exp_classic(int lq);
    return (lq > 200) ? 0 : 10;  // R1
  endfunction

  // R2/R3/R5 model in Q4: 0 + e*8 + I*2, round half up, clamp
  function automatic int exp_le(int e, int isum);
    int q;
    int r;
    q = e * 8 + isum * 2;
    r = (q + 8) >>> 4;
    if (r < -20) r = -20;
    if (r > 10)  r = 10;
    return r;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_event(bit le, int lq, int rssi, string req);
    @(negedge clk_i);
    evt_valid_i = 1'b1;
    slot_le_i   = le;
    lq_i        = 8'(lq);
    rssi_i      = 8'(rssi);
    if (le) begin
      int e;
      e = -65 - rssi;
      m_integ += e;
      m_pwr = exp_le(e, m_integ);
      if (m_cnt == 9) begin
        m_integ = 0;
        m_cnt = 0;
      end else m_cnt++;
    end else m_pwr = exp_classic(lq);
    @(posedge clk_i);
    #1;
    evt_valid_i = 1'b0;
    check(req, int'(pwr_o), m_pwr);
  endtask

  task automatic idle_noise(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      slot_le_i = 1'($urandom);
      lq_i      = 8'($urandom);
      rssi_i    = 8'($urandom);
    end
    @(posedge clk_i);
    #1;
    check("R6", int'(pwr_o), m_pwr);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1;
    check("R8", int'(pwr_o), 0);
    rst_ni = 1'b1;

    // R1 threshold boundaries
    do_event(1'b0, 200, 0, "R1");
    do_event(1'b0, 201, 0, "R1");
    do_event(1'b0, 0, 0, "R1");
    do_event(1'b0, 255, 0, "R1");
    idle_noise(4);

    // R2 on target: e=0 gives 0 dBm
    do_event(1'b1, 0, -65, "R2");
    // R3 e=1, I=1: 0.625 rounds up to 1
    do_event(1'b1, 0, -66, "R3");
    // R3 e=-1, I=0: -0.5 + 0 = -0.5 -> rounds to 0 (half toward +inf)
    do_event(1'b1, 0, -64, "R3");
    // R7 classic event in the middle of a window
    do_event(1'b0, 50, 0, "R7");
    do_event(1'b1, 0, -70, "R7");
    // R5 both clamps
    do_event(1'b1, 0, -128, "R5");
    do_event(1'b1, 0, 127, "R5");
    // R4 fill the window and check a fresh start
    for (int i = 0; i < 12; i++) do_event(1'b1, 0, -75, "R4");
    idle_noise(3);

    // random mix
    for (int i = 0; i < 400; i++) begin
      bit le;
      int rs;
      le = ($urandom_range(3) != 0);
      if ($urandom_range(7) == 0) rs = int'($signed(8'($urandom)));
      else rs = -65 + int'($urandom_range(30)) - 15;
      do_event(le, int'($urandom_range(255)), rs, le ? "R2" : "R1");
      if ($urandom_range(5) == 0) idle_noise(int'($urandom_range(3)) + 1);
    end

    // R8 reset mid-window clears the integrator
    do_event(1'b1, 0, -90, "R4");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R8", int'(pwr_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_integ = 0;
    m_cnt = 0;
    m_pwr = 0;
    do_event(1'b1, 0, -67, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule